// File: doc/BRIEF.md
# I2C Target Controller with 7-bit and 10-bit Addressing

This block is the target (slave) side of an I2C bus. It runs on a system clock much faster than the bus, brings SCL and SDA in through two-flop synchronizers, and finds START and STOP conditions with edge detectors. It drives both bus lines only through open-drain pull-down enables. One configuration input chooses between a single-byte 7-bit address and a two-byte 10-bit address. Both are compared against an own-address input.

Received data bytes appear on a one-entry valid/ready output register. Bytes to send are taken from a valid/ready input. A one-cycle `byte_done` event marks every completed data byte. The block inserts wait states by holding SCL low. As a transmitter it always holds SCL until local logic supplies the next byte. As a receiver it holds SCL only when `cfg_rx_stretch` is set, until the received byte has been taken. With stretching off, a byte that arrives while the previous one is still unread is declined.

The controller is a single state machine:
- `ST_IDLE`: waits for START.
- `ST_ADDR_HI`: shifts in the first address byte.
- `ST_ADDR_LO`: shifts in the low byte of a 10-bit address.
- `ST_ACK_ADDR`: pulls SDA low for an address acknowledge.
- `ST_RX_BYTE`: shifts in a data byte.
- `ST_RX_ACK`: acknowledges a data byte, or declines it.
- `ST_RX_HOLD`: stretches SCL until the received byte is taken.
- `ST_TX_LOAD`: stretches SCL and raises `tx_ready` until a byte is supplied.
- `ST_TX_BYTE`: drives data bits.
- `ST_TX_ACK`: samples the controller's acknowledge.
- `ST_IGNORE`: releases the bus until the next START or STOP.

Transitions:
- A START moves from any state to `ST_ADDR_HI`. A STOP moves from any state to `ST_IDLE`.
- From `ST_ADDR_HI`, a matching byte goes to `ST_ACK_ADDR`; any other byte goes to `ST_IGNORE`. `ST_ADDR_LO` does the same for the low byte.
- The ninth SCL fall leaves `ST_ACK_ADDR` for `ST_ADDR_LO` (10-bit write header), `ST_TX_LOAD` (read) or `ST_RX_BYTE` (write).
- `ST_RX_BYTE` goes to `ST_RX_ACK` after eight bits.
- `ST_RX_ACK` goes to `ST_RX_HOLD` when stretching is enabled and the byte is unread; otherwise it returns to `ST_RX_BYTE`.
- `ST_RX_HOLD` goes to `ST_RX_BYTE` once the byte is taken.
- `ST_TX_LOAD` goes to `ST_TX_BYTE` on `tx_valid`.
- `ST_TX_BYTE` goes to `ST_TX_ACK` after eight bits.
- `ST_TX_ACK` goes to `ST_TX_LOAD` on ACK and to `ST_IGNORE` on NACK.

Top module: `i2c_target_ctrl`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `rx_valid`, `tx_ready` and `selected` are all 0.
- R2: In 7-bit mode (`cfg_ten_bit`=0) the first byte after START holds the address in bits 7:1, MSB first, and R/W in bit 0 (0 = write). The target pulls SDA low on the ninth clock only when bits 7:1 equal `cfg_own_addr[6:0]`. Otherwise SDA stays released and the bus is ignored until the next START or STOP.
- R3: In 10-bit mode the first byte is 1,1,1,1,0,A9,A8,R/W. It is acknowledged only when A9:A8 equal `cfg_own_addr[9:8]`. For a write header, the next byte carries A7..A0 and is acknowledged only when it equals `cfg_own_addr[7:0]`.
- R4: In 10-bit mode a header with R/W=1 is acknowledged on its own only if a full 10-bit match has occurred since the last STOP. Otherwise it is not acknowledged.
- R5: Write data is received MSB first, with any number of bytes per address. Each accepted byte is presented on `rx_data` with `rx_valid` and acknowledged on the ninth clock. `byte_done` pulses once per byte. `rx_data` stays stable while `rx_valid` is set and `rx_ready` is low.
- R6: A data byte that completes while `rx_valid` is still set is declined: SDA stays released on its ninth clock and `rx_data` keeps the earlier byte.
- R7: With `cfg_rx_stretch`=1, after the acknowledge of a data byte SCL is held low while `rx_valid` is set. It is released once the byte has been taken.
- R8: After an acknowledged read address, or a transmitted byte that the controller acknowledged, SCL is held low with `tx_ready`=1 until `tx_valid`. The byte is then sent MSB first. `tx_ready` is never high unless SCL is held.
- R9: When the controller does not acknowledge a transmitted byte, the target releases SDA and requests no further byte until the next START or STOP.
- R10: START (SDA falling while SCL is high) restarts address matching from any state. STOP (SDA rising while SCL is high) releases both lines in the next cycle, clears `selected` and forgets any 10-bit match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times the bus rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (wait state) |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_own_addr | input | 10 | Own address; bits 6:0 used in 7-bit mode |
| cfg_rx_stretch | input | 1 | 1 allows SCL stretching while receiving |
| rx_data | output | 8 | Last accepted write byte |
| rx_valid | output | 1 | `rx_data` holds an unread byte |
| rx_ready | input | 1 | Local logic takes `rx_data` |
| tx_data | input | 8 | Next byte to transmit |
| tx_valid | input | 1 | `tx_data` is available |
| tx_ready | output | 1 | Target takes `tx_data` this cycle if valid |
| byte_done | output | 1 | One-cycle pulse per completed data byte |
| selected | output | 1 | Target is addressed in the current transfer |

## Verification
A behavioural bus controller drives a vector table of 7-bit and 10-bit write addresses. The table includes a hit, a 7-bit miss, a 10-bit header miss and a miss in the low byte only, which separates the one-byte compare from each half of the two-byte compare. Directed transfers then cover:
- multi-byte writes, and a declined byte while the output register is still full;
- 7-bit and 10-bit reads, where the 10-bit read is shortened after a repeated START and the same header is refused after a STOP;
- a NACK that ends a read;
- SCL held low in both directions until the byte interface responds, measured on the bus line itself.

// File: rtl/i2c_target_pkg.sv
package i2c_target_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_ACK_ADDR,
        ST_RX_BYTE,
        ST_RX_ACK,
        ST_RX_HOLD,
        ST_TX_LOAD,
        ST_TX_BYTE,
        ST_TX_ACK,
        ST_IGNORE
    } tgt_state_t;

    // Fixed leading pattern of a 10-bit address header byte
    localparam logic [4:0] TEN_BIT_HDR = 5'b11110;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-1:0], line_in};
        end
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic scl_level,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_det,
    output logic stop_det
);
    assign start_det = scl_level & sda_fall;
    assign stop_det  = scl_level & sda_rise;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_target_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              hit_seven,
    output logic              hit_header,
    output logic              hit_low
);
    localparam int HI_W = ADDR_W - DATA_W;

    assign hit_seven  = (rx_byte[DATA_W-1:1] == own_addr[DATA_W-2:0]);
    assign hit_header = (rx_byte[DATA_W-1:HI_W+1] == TEN_BIT_HDR)
                      && (rx_byte[HI_W:1] == own_addr[ADDR_W-1:DATA_W]);
    assign hit_low    = (rx_byte == own_addr[DATA_W-1:0]);
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
    import i2c_target_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              cfg_ten_bit,
    input  logic [ADDR_W-1:0] cfg_own_addr,
    input  logic              cfg_rx_stretch,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              byte_done,
    output logic              selected
);
    localparam int              CNT_W   = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] RX_LAST = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(DATA_W - 1);
    localparam int              N_LINES = 2;

    // line index 0 = SCL, 1 = SDA
    logic [N_LINES-1:0] raw_lines, lvl, rse, fll;
    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_in(raw_lines[g]),
            .level  (lvl[g]),
            .rise   (rse[g]),
            .fall   (fll[g])
        );
    end

    logic scl_lvl, scl_rise, scl_fall, sda_lvl;
    assign scl_lvl  = lvl[0];
    assign scl_rise = rse[0];
    assign scl_fall = fll[0];
    assign sda_lvl  = lvl[1];

    logic start_det, stop_det;
    i2c_cond_detect u_cond (
        .scl_level(scl_lvl),
        .sda_rise (rse[1]),
        .sda_fall (fll[1]),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    tgt_state_t        state, nxt;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              rw_q, need_lo, ten_ok, ack_q, tx_acked;

    logic hit_seven, hit_header, hit_low;
    i2c_addr_match #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_match (
        .rx_byte   (shreg),
        .own_addr  (cfg_own_addr),
        .hit_seven (hit_seven),
        .hit_header(hit_header),
        .hit_low   (hit_low)
    );

    logic byte_in, addr_ok_hi;
    assign byte_in    = scl_fall && (bit_cnt == RX_LAST);
    assign addr_ok_hi = cfg_ten_bit ? (hit_header && (!shreg[0] || ten_ok))
                                    : hit_seven;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     nxt = ST_IDLE;
            ST_ADDR_HI:  if (byte_in) nxt = addr_ok_hi ? ST_ACK_ADDR : ST_IGNORE;
            ST_ADDR_LO:  if (byte_in) nxt = hit_low ? ST_ACK_ADDR : ST_IGNORE;
            ST_ACK_ADDR: if (scl_fall) begin
                             if (need_lo)   nxt = ST_ADDR_LO;
                             else if (rw_q) nxt = ST_TX_LOAD;
                             else           nxt = ST_RX_BYTE;
                         end
            ST_RX_BYTE:  if (byte_in) nxt = ST_RX_ACK;
            ST_RX_ACK:   if (scl_fall)
                             nxt = (cfg_rx_stretch && rx_valid) ? ST_RX_HOLD : ST_RX_BYTE;
            ST_RX_HOLD:  if (!rx_valid) nxt = ST_RX_BYTE;
            ST_TX_LOAD:  if (tx_valid) nxt = ST_TX_BYTE;
            ST_TX_BYTE:  if (scl_fall && (bit_cnt == TX_LAST)) nxt = ST_TX_ACK;
            ST_TX_ACK:   if (scl_fall) nxt = tx_acked ? ST_TX_LOAD : ST_IGNORE;
            ST_IGNORE:   nxt = ST_IGNORE;
            default:     nxt = ST_IDLE;
        endcase
        if (start_det)     nxt = ST_ADDR_HI;
        else if (stop_det) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            rw_q      <= 1'b0;
            need_lo   <= 1'b0;
            ten_ok    <= 1'b0;
            ack_q     <= 1'b0;
            tx_acked  <= 1'b0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (rx_valid && rx_ready) rx_valid <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
                if (stop_det) ten_ok <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR_HI, ST_ADDR_LO, ST_RX_BYTE: begin
                        if (scl_rise && (bit_cnt != RX_LAST)) begin
                            shreg   <= {shreg[DATA_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (byte_in && state == ST_ADDR_HI) begin
                            rw_q    <= shreg[0];
                            need_lo <= cfg_ten_bit && !shreg[0];
                            if (cfg_ten_bit && !shreg[0]) ten_ok <= 1'b0;
                        end
                        if (byte_in && state == ST_ADDR_LO) begin
                            need_lo <= 1'b0;
                            if (hit_low) ten_ok <= 1'b1;
                        end
                        if (byte_in && state == ST_RX_BYTE) begin
                            if (rx_valid) begin
                                ack_q <= 1'b0;
                            end else begin
                                ack_q     <= 1'b1;
                                rx_data   <= shreg;
                                rx_valid  <= 1'b1;
                                byte_done <= 1'b1;
                            end
                        end
                    end
                    ST_ACK_ADDR, ST_RX_ACK: begin
                        if (scl_fall) bit_cnt <= '0;
                    end
                    ST_TX_LOAD: begin
                        if (tx_valid) begin
                            shreg   <= tx_data;
                            bit_cnt <= '0;
                        end
                    end
                    ST_TX_BYTE: begin
                        if (scl_fall && (bit_cnt != TX_LAST)) begin
                            shreg   <= {shreg[DATA_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) tx_acked  <= ~sda_lvl;
                        if (scl_fall) byte_done <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe   = 1'b0;
        scl_oe   = 1'b0;
        tx_ready = 1'b0;
        selected = 1'b0;
        unique case (state)
            ST_ACK_ADDR: begin sda_oe = 1'b1;           selected = 1'b1; end
            ST_RX_BYTE:  selected = 1'b1;
            ST_RX_ACK:   begin sda_oe = ack_q;          selected = 1'b1; end
            ST_RX_HOLD:  begin scl_oe = 1'b1;           selected = 1'b1; end
            ST_TX_LOAD:  begin scl_oe = 1'b1; tx_ready = 1'b1; selected = 1'b1; end
            ST_TX_BYTE:  begin sda_oe = ~shreg[DATA_W-1]; selected = 1'b1; end
            ST_TX_ACK:   selected = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_target_ctrl_chk.sv
module i2c_target_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_seen,
    input logic              stop_seen,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_ready,
    input logic              byte_done,
    input logic              selected
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> !scl_oe && !sda_oe && !rx_valid && !tx_ready);

    assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

    assert_rx_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> byte_done);

    assert_stretch_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !scl_seen);

    assert_tx_ready_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> scl_oe);

    assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !sda_oe && !scl_oe && !selected);
endmodule

bind i2c_target_ctrl i2c_target_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_seen (scl_lvl),
    .stop_seen(stop_det),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .tx_ready (tx_ready),
    .byte_done(byte_done),
    .selected (selected)
);

// File: tb/i2c_target_ctrl_test.sv
`timescale 1ns/1ps
module i2c_target_ctrl_test;
    localparam int         Q   = 10;
    localparam logic [9:0] OWN = 10'h2A5;
    localparam int         NV  = 5;
    // {ten_bit, address[9:0], expect_ack, data[7:0]}
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 10'h025, 1'b1, 8'hC3},
        {1'b0, 10'h024, 1'b0, 8'h00},
        {1'b1, 10'h2A5, 1'b1, 8'h5A},
        {1'b1, 10'h1A5, 1'b0, 8'h00},
        {1'b1, 10'h2A4, 1'b0, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_oe, sda_oe, scl_line, sda_line;
    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    logic       cfg_ten_bit = 1'b0, cfg_rx_stretch = 1'b0;
    logic [7:0] rx_data, tx_data;
    logic       rx_valid, rx_ready, tx_valid, tx_ready, byte_done, selected;
    logic       rx_auto = 1'b1, tx_en = 1'b0;
    logic [7:0] tx_mem [4] = '{8'h96, 8'h3C, 8'hA7, 8'hD2};
    logic [7:0] rx_log [16];
    int         tx_idx = 0, rx_cnt = 0, bd_cnt = 0;
    int         checks = 0, errors = 0;

    assign rx_ready = rx_auto;
    assign tx_valid = tx_en;
    assign tx_data  = tx_mem[tx_idx[1:0]];

    always @(posedge clk) begin
        if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
        if (rx_valid && rx_ready) begin
            rx_log[rx_cnt[3:0]] <= rx_data;
            rx_cnt <= rx_cnt + 1;
        end
        if (byte_done) bd_cnt <= bd_cnt + 1;
    end

    i2c_target_ctrl uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_ten_bit(cfg_ten_bit),
        .cfg_own_addr(OWN), .cfg_rx_stretch(cfg_rx_stretch),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .byte_done(byte_done), .selected(selected)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wait_scl_high(); wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wait_scl_high(); wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic write_bit(input logic b);
        m_sda = b; wq(Q);
        m_scl = 1'b1; wait_scl_high(); wq(2*Q);
        m_scl = 1'b0; wq(2);
    endtask

    task automatic read_bit(output logic b);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wait_scl_high(); wq(Q);
        b = sda_line; wq(Q);
        m_scl = 1'b0; wq(2);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) write_bit(d[i]);
        read_bit(b);
        acked = ~b;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            read_bit(b);
            d[i] = b;
        end
        write_bit(~give_ack);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic       ack, hi_exp, b0;
        logic [7:0] d;
        int         base;

        wq(5);
        chk(scl_oe == 0 && sda_oe == 0, "R1 lines released in reset", {scl_oe, sda_oe}, 0);
        chk(rx_valid == 0 && tx_ready == 0 && selected == 0, "R1 handshakes idle in reset",
            {rx_valid, tx_ready, selected}, 0);
        rst_n = 1'b1; wq(5);
        chk(scl_oe == 0 && sda_oe == 0 && selected == 0, "R1 idle after reset",
            {scl_oe, sda_oe, selected}, 0);

        // vector table: write transfers in both address modes
        for (int v = 0; v < NV; v++) begin
            cfg_ten_bit = VEC[v][19];
            base = rx_cnt;
            bus_start();
            if (!VEC[v][19]) begin
                wbyte({VEC[v][15:9], 1'b0}, ack);
                chk(ack == VEC[v][8], $sformatf("R2 vec%0d 7-bit ack", v), ack, VEC[v][8]);
            end else begin
                hi_exp = (VEC[v][18:17] == OWN[9:8]);
                wbyte({5'b11110, VEC[v][18:17], 1'b0}, ack);
                chk(ack == hi_exp, $sformatf("R3 vec%0d header ack", v), ack, hi_exp);
                if (ack) begin
                    wbyte(VEC[v][16:9], ack);
                    chk(ack == VEC[v][8], $sformatf("R3 vec%0d low byte ack", v), ack, VEC[v][8]);
                end
            end
            if (ack) begin
                wbyte(VEC[v][7:0], ack);
                chk(ack == 1'b1, $sformatf("R5 vec%0d data ack", v), ack, 1);
                wq(4);
                chk(rx_log[base[3:0]] == VEC[v][7:0], $sformatf("R5 vec%0d data value", v),
                    rx_log[base[3:0]], VEC[v][7:0]);
            end else begin
                chk(sda_oe == 0, $sformatf("R2 vec%0d SDA released after miss", v), sda_oe, 0);
            end
            bus_stop(); wq(5);
        end

        // multi-byte write
        cfg_ten_bit = 1'b0;
        base = rx_cnt;
        begin
            int bd0;
            bd0 = bd_cnt;
            bus_start();
            wbyte({OWN[6:0], 1'b0}, ack);
            for (int i = 0; i < 3; i++) begin
                wbyte(8'h11 * (i + 1), ack);
                chk(ack == 1'b1, "R5 multi-byte ack", ack, 1);
            end
            wq(4);
            for (int i = 0; i < 3; i++)
                chk(rx_log[(base + i) % 16] == 8'h11 * (i + 1), "R5 multi-byte data",
                    rx_log[(base + i) % 16], 8'h11 * (i + 1));
            chk(bd_cnt - bd0 == 3, "R5 byte_done count", bd_cnt - bd0, 3);
            bus_stop(); wq(5);
        end

        // declined byte while output register is full
        rx_auto = 1'b0;
        bus_start();
        wbyte({OWN[6:0], 1'b0}, ack);
        wbyte(8'hA1, ack);
        chk(ack == 1'b1, "R6 first byte accepted", ack, 1);
        wbyte(8'hB2, ack);
        chk(ack == 1'b0, "R6 second byte declined", ack, 0);
        chk(rx_valid == 1 && rx_data == 8'hA1, "R6 earlier byte kept", rx_data, 8'hA1);
        bus_stop();
        rx_auto = 1'b1; wq(5);

        // receive-side clock stretching
        cfg_rx_stretch = 1'b1; rx_auto = 1'b0;
        bus_start();
        wbyte({OWN[6:0], 1'b0}, ack);
        wbyte(8'h4E, ack);
        chk(ack == 1'b1 && rx_data == 8'h4E, "R7 byte accepted before hold", rx_data, 8'h4E);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(60);
        chk(scl_line == 0, "R7 SCL held while byte unread", scl_line, 0);
        rx_auto = 1'b1; wq(10);
        chk(scl_line == 1, "R7 SCL released after read", scl_line, 1);
        wq(Q); m_scl = 1'b0; wq(2);
        bus_stop(); wq(5);
        cfg_rx_stretch = 1'b0;

        // 7-bit read ending with NACK
        tx_en = 1'b1;
        bus_start();
        wbyte({OWN[6:0], 1'b1}, ack);
        chk(ack == 1'b1, "R2 read address ack", ack, 1);
        rbyte(d, 1'b1);
        chk(d == 8'h96, "R8 first read byte", d, 8'h96);
        rbyte(d, 1'b0);
        chk(d == 8'h3C, "R8 second read byte", d, 8'h3C);
        wq(40);
        chk(sda_oe == 0 && tx_ready == 0 && scl_oe == 0, "R9 released after NACK",
            {sda_oe, tx_ready, scl_oe}, 0);
        chk(tx_idx == 2, "R9 no byte requested after NACK", tx_idx, 2);
        bus_stop(); wq(5);

        // transmit-side clock stretching
        tx_en = 1'b0;
        bus_start();
        wbyte({OWN[6:0], 1'b1}, ack);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(60);
        chk(scl_line == 0 && tx_ready == 1, "R8 SCL held until byte supplied",
            {scl_line, tx_ready}, 1);
        tx_en = 1'b1; wq(10);
        chk(scl_line == 1, "R8 SCL released after byte supplied", scl_line, 1);
        wq(Q); b0 = sda_line; wq(Q);
        m_scl = 1'b0; wq(2);
        d[7] = b0;
        for (int i = 6; i >= 0; i--) begin
            logic bb;
            read_bit(bb);
            d[i] = bb;
        end
        write_bit(1'b1);
        chk(d == 8'hA7, "R8 stretched byte MSB first", d, 8'hA7);
        bus_stop(); wq(5);

        // 10-bit read with short header after repeated START
        cfg_ten_bit = 1'b1;
        bus_start();
        wbyte({5'b11110, OWN[9:8], 1'b0}, ack);
        wbyte(OWN[7:0], ack);
        chk(ack == 1'b1, "R3 full 10-bit match", ack, 1);
        bus_start();
        wbyte({5'b11110, OWN[9:8], 1'b1}, ack);
        chk(ack == 1'b1, "R4 read header after full match", ack, 1);
        rbyte(d, 1'b0);
        chk(d == 8'hD2, "R4 10-bit read data", d, 8'hD2);
        bus_stop(); wq(5);
        chk(selected == 0 && scl_oe == 0 && sda_oe == 0, "R10 idle after STOP",
            {selected, scl_oe, sda_oe}, 0);

        // read header refused after STOP cleared the match
        bus_start();
        wbyte({5'b11110, OWN[9:8], 1'b1}, ack);
        chk(ack == 1'b0, "R4 read header refused after STOP", ack, 0);
        bus_stop(); wq(5);

        // repeated START restarts matching after a miss
        cfg_ten_bit = 1'b0;
        bus_start();
        wbyte({7'h24, 1'b0}, ack);
        chk(ack == 1'b0, "R2 miss before repeated start", ack, 0);
        bus_start();
        wbyte({OWN[6:0], 1'b0}, ack);
        chk(ack == 1'b1 && selected == 1, "R10 repeated START rematches", {ack, selected}, 3);
        bus_stop(); wq(5);
        chk(selected == 0, "R10 deselected by STOP", selected, 0);

        finish_run();
    end
endmodule